// File: doc/BRIEF.md
# Eight-Channel Pin Interrupt Controller

The block turns eight synchronous input lines into eight interrupt requests. Each channel is set on its own to edge or level sensitivity. In edge mode the channel fires on a rising edge, a falling edge or both. In level mode it fires while its input is high, or while it is low. Software programs the block through a small word-addressed register bank. The two enable registers can be written directly, or changed bit by bit through set and clear aliases, so software needs no read-modify-write.

Every edge on every channel is recorded in an up-latch and a down-latch, whatever the enables and the mode. The request of an edge-mode channel is built from these latches and its two enables. A level-mode channel compares the live input with a polarity bit. That polarity bit is the falling-edge enable, reused. Writing a one to a channel's bit in the request register acknowledges the channel. In edge mode this clears both latches of the channel. In level mode it flips the polarity, which lets software track the next change of the input. Interrupt output n always equals request bit n.

Top module: `pin_irq_unit`

## Requirements
- R1: After reset, every register reads 0 and all interrupt outputs are low.
- R2: A write to 0x00 (mode, bit n = 1 selects level mode for channel n), 0x04 (up-enable) or 0x10 (down-enable) loads the register, and a read of the same offset returns it.
- R3: Writing ones to 0x08 or 0x14 sets those bits of the up-enable or down-enable. Writing ones to 0x0C or 0x18 clears them. Zero bits leave the other bits unchanged.
- R4: A 0→1 change of input n sets bit n of the up-latch (0x1C), and a 1→0 change sets bit n of the down-latch (0x20). The bit is set at the first clock edge that samples the new value, whatever the enables and the mode.
- R5: Writing ones to 0x1C or 0x20 clears those latch bits. If a new edge arrives in the same cycle as the clear, the latch bit stays set.
- R6: In edge mode, request bit n is (up-latch & up-enable) | (down-latch & down-enable). Both terms may be active at once.
- R7: In level mode, request bit n is up-enable[n] AND (input[n] equals down-enable[n]). A down-enable bit of 1 means active-high and 0 means active-low. The request follows the live input with no latching.
- R8: Writing a one to bit n of 0x24 while channel n is in edge mode clears both of its latch bits. Zero bits have no effect.
- R9: Writing a one to bit n of 0x24 while channel n is in level mode inverts down-enable bit n and leaves the latches unchanged.
- R10: Reading 0x24 returns the request vector, and interrupt output n equals request bit n in every cycle.
- R11: Reads of the alias offsets (0x08, 0x0C, 0x14, 0x18) and of unmapped offsets return 0. Register bits above the channel count read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| chan_in | input | 8 | Channel inputs, synchronous to clk |
| irq | output | 8 | Interrupt request per channel |

## Verification
The bench drives an edge into a channel in the same cycle that software clears its latch. A design that lets the clear win would lose that edge. In level mode it moves the input against both polarities and issues an acknowledge. A design that clears latches or holds the request there, instead of flipping the polarity, shows up at the down-enable readback and at irq. The alias writes use partial masks and all-zero masks, so a design that writes whole values through an alias corrupts the untouched bits. A channel with both edge enables set must fire on either edge, and a channel whose edge has no matching enable must stay quiet.

// File: rtl/pirq_pkg.sv
// Package: register offsets and the decoded write-select bundle shared by
// the pin interrupt unit. Assumes byte offsets on a 32-bit register grid.
package pirq_pkg;
    localparam int unsigned OFF_MODE    = 'h00;
    localparam int unsigned OFF_UP_EN   = 'h04;
    localparam int unsigned OFF_UP_SET  = 'h08;
    localparam int unsigned OFF_UP_CLR  = 'h0C;
    localparam int unsigned OFF_DN_EN   = 'h10;
    localparam int unsigned OFF_DN_SET  = 'h14;
    localparam int unsigned OFF_DN_CLR  = 'h18;
    localparam int unsigned OFF_UP_LAT  = 'h1C;
    localparam int unsigned OFF_DN_LAT  = 'h20;
    localparam int unsigned OFF_REQ     = 'h24;

    // One strobe per writable register, at most one high in a cycle.
    typedef struct packed {
        logic mode;
        logic up_en;
        logic up_set;
        logic up_clr;
        logic dn_en;
        logic dn_set;
        logic dn_clr;
        logic up_lat;
        logic dn_lat;
        logic req;
    } pirq_wsel_t;
endpackage

// File: rtl/pirq_decode.sv
// Module: turns a write strobe plus address into one-hot register selects.
// Assumes the address is stable while bus_wr is high.
module pirq_decode
    import pirq_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    output pirq_wsel_t    wsel
);
    // Address compare for every writable register.
    always_comb begin
        wsel        = '0;
        wsel.mode   = bus_wr && (bus_addr == AW'(OFF_MODE));
        wsel.up_en  = bus_wr && (bus_addr == AW'(OFF_UP_EN));
        wsel.up_set = bus_wr && (bus_addr == AW'(OFF_UP_SET));
        wsel.up_clr = bus_wr && (bus_addr == AW'(OFF_UP_CLR));
        wsel.dn_en  = bus_wr && (bus_addr == AW'(OFF_DN_EN));
        wsel.dn_set = bus_wr && (bus_addr == AW'(OFF_DN_SET));
        wsel.dn_clr = bus_wr && (bus_addr == AW'(OFF_DN_CLR));
        wsel.up_lat = bus_wr && (bus_addr == AW'(OFF_UP_LAT));
        wsel.dn_lat = bus_wr && (bus_addr == AW'(OFF_DN_LAT));
        wsel.req    = bus_wr && (bus_addr == AW'(OFF_REQ));
    end
endmodule

// File: rtl/pirq_ctrl_regs.sv
// Module: mode, up-enable and down-enable registers with direct, set and
// clear write paths. A level-mode acknowledge inverts the down-enable bit.
// Assumes at most one select is high per cycle.
module pirq_ctrl_regs
    import pirq_pkg::*;
#(
    parameter int CH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  pirq_wsel_t    wsel,
    input  logic [CH-1:0] wbits,
    input  logic [CH-1:0] pol_flip,
    output logic [CH-1:0] mode_q,
    output logic [CH-1:0] up_en_q,
    output logic [CH-1:0] dn_en_q
);
    // Mode register: direct write only.
    always_ff @(posedge clk) begin
        if (!rst_n)         mode_q <= '0;
        else if (wsel.mode) mode_q <= wbits;
    end

    // Up-enable: direct load, or per-bit set / clear through the aliases.
    always_ff @(posedge clk) begin
        if (!rst_n)           up_en_q <= '0;
        else if (wsel.up_en)  up_en_q <= wbits;
        else if (wsel.up_set) up_en_q <= up_en_q | wbits;
        else if (wsel.up_clr) up_en_q <= up_en_q & ~wbits;
    end

    // Down-enable (also level polarity): load, set, clear, or ack toggle.
    always_ff @(posedge clk) begin
        if (!rst_n)           dn_en_q <= '0;
        else if (wsel.dn_en)  dn_en_q <= wbits;
        else if (wsel.dn_set) dn_en_q <= dn_en_q | wbits;
        else if (wsel.dn_clr) dn_en_q <= dn_en_q & ~wbits;
        else                  dn_en_q <= dn_en_q ^ pol_flip;
    end
endmodule

// File: rtl/pirq_edge_capture.sv
// Module: per-channel edge detector with sticky up and down latches.
// A newly seen edge has priority over a clear in the same cycle.
// Assumes chan_in is already synchronous to clk.
module pirq_edge_capture #(
    parameter int CH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CH-1:0] chan_in,
    input  logic [CH-1:0] up_clr,
    input  logic [CH-1:0] dn_clr,
    output logic [CH-1:0] up_lat,
    output logic [CH-1:0] dn_lat
);
    logic [CH-1:0] prev_q;

    // Previous input sample, the reference for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= chan_in;
    end

    for (genvar n = 0; n < CH; n++) begin : g_chan
        logic rise_seen;
        logic fall_seen;
        assign rise_seen =  chan_in[n] & ~prev_q[n];
        assign fall_seen = ~chan_in[n] &  prev_q[n];

        // Up-latch: set by a rising edge, cleared on request otherwise.
        always_ff @(posedge clk) begin
            if (!rst_n)          up_lat[n] <= 1'b0;
            else if (rise_seen)  up_lat[n] <= 1'b1;
            else if (up_clr[n])  up_lat[n] <= 1'b0;
        end

        // Down-latch: set by a falling edge, cleared on request otherwise.
        always_ff @(posedge clk) begin
            if (!rst_n)          dn_lat[n] <= 1'b0;
            else if (fall_seen)  dn_lat[n] <= 1'b1;
            else if (dn_clr[n])  dn_lat[n] <= 1'b0;
        end
    end
endmodule

// File: rtl/pirq_request.sv
// Module: forms the request of each channel from its mode, enables,
// latches and live input. Purely combinational.
module pirq_request #(
    parameter int CH = 8
) (
    input  logic [CH-1:0] mode,
    input  logic [CH-1:0] up_en,
    input  logic [CH-1:0] dn_en,
    input  logic [CH-1:0] up_lat,
    input  logic [CH-1:0] dn_lat,
    input  logic [CH-1:0] chan_in,
    output logic [CH-1:0] req
);
    for (genvar n = 0; n < CH; n++) begin : g_chan
        logic edge_req;
        logic level_req;
        assign edge_req  = (up_lat[n] & up_en[n]) | (dn_lat[n] & dn_en[n]);
        assign level_req = up_en[n] & (chan_in[n] == dn_en[n]);
        // Mode bit picks the level or edge form of the request.
        assign req[n]    = mode[n] ? level_req : edge_req;
    end
endmodule

// File: rtl/pin_irq_unit.sv
// Module: eight-channel pin interrupt controller with a register bank.
// Writes take effect at the clock edge, reads are combinational.
// Assumes a single-master bus and synchronous channel inputs.
module pin_irq_unit
    import pirq_pkg::*;
#(
    parameter int CH = 8,
    parameter int AW = 6,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [CH-1:0] chan_in,
    output logic [CH-1:0] irq
);
    localparam int SPARE = DW - CH;

    pirq_wsel_t    wsel;
    logic [CH-1:0] wbits;
    logic [CH-1:0] ack_bits;
    logic [CH-1:0] pol_flip;
    logic [CH-1:0] up_clr;
    logic [CH-1:0] dn_clr;
    logic [CH-1:0] mode_q;
    logic [CH-1:0] up_en_q;
    logic [CH-1:0] dn_en_q;
    logic [CH-1:0] up_lat;
    logic [CH-1:0] dn_lat;
    logic [CH-1:0] req;

    assign wbits = bus_wdata[CH-1:0];

    if (SPARE > 0) begin : g_spare
        logic unused_hi;
        assign unused_hi = ^bus_wdata[DW-1:CH];
    end

    pirq_decode #(.AW(AW)) u_decode (
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .wsel     (wsel)
    );

    // Acknowledge routing: edge channels clear latches, level ones flip polarity.
    always_comb begin
        ack_bits = wsel.req ? wbits : '0;
        pol_flip = ack_bits & mode_q;
        up_clr   = (wsel.up_lat ? wbits : '0) | (ack_bits & ~mode_q);
        dn_clr   = (wsel.dn_lat ? wbits : '0) | (ack_bits & ~mode_q);
    end

    pirq_ctrl_regs #(.CH(CH)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wsel     (wsel),
        .wbits    (wbits),
        .pol_flip (pol_flip),
        .mode_q   (mode_q),
        .up_en_q  (up_en_q),
        .dn_en_q  (dn_en_q)
    );

    pirq_edge_capture #(.CH(CH)) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .chan_in (chan_in),
        .up_clr  (up_clr),
        .dn_clr  (dn_clr),
        .up_lat  (up_lat),
        .dn_lat  (dn_lat)
    );

    pirq_request #(.CH(CH)) u_request (
        .mode    (mode_q),
        .up_en   (up_en_q),
        .dn_en   (dn_en_q),
        .up_lat  (up_lat),
        .dn_lat  (dn_lat),
        .chan_in (chan_in),
        .req     (req)
    );

    assign irq = req;

    // Read mux: readable registers return their value, all else reads 0.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            AW'(OFF_MODE):   bus_rdata[CH-1:0] = mode_q;
            AW'(OFF_UP_EN):  bus_rdata[CH-1:0] = up_en_q;
            AW'(OFF_DN_EN):  bus_rdata[CH-1:0] = dn_en_q;
            AW'(OFF_UP_LAT): bus_rdata[CH-1:0] = up_lat;
            AW'(OFF_DN_LAT): bus_rdata[CH-1:0] = dn_lat;
            AW'(OFF_REQ):    bus_rdata[CH-1:0] = req;
            default:         bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pin_irq_unit_chk.sv
// Module: property checker for pin_irq_unit, attached by bind below.
// Keeps its own copy of the previous input sample to judge edges.
module pin_irq_unit_chk #(
    parameter int CH = 8,
    parameter int AW = 6,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [CH-1:0] wr_bits,
    input  logic [DW-1:0] bus_rdata,
    input  logic [CH-1:0] chan_in,
    input  logic [CH-1:0] irq,
    input  logic [CH-1:0] mode_q,
    input  logic [CH-1:0] up_en_q,
    input  logic [CH-1:0] dn_en_q,
    input  logic [CH-1:0] up_lat
);
    logic [CH-1:0] seen_q;
    logic [CH-1:0] rises;

    // Checker's own record of the last input sample.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= '0;
        else        seen_q <= chan_in;
    end
    assign rises = chan_in & ~seen_q;

    AST_REQ_READ_IS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == AW'('h24)) |-> (bus_rdata == DW'(irq))); // R10

    AST_UP_SET_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == AW'('h08)) |=> ((up_en_q & $past(wr_bits)) == $past(wr_bits))); // R3

    AST_UP_CLR_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == AW'('h0C)) |=> ((up_en_q & $past(wr_bits)) == '0)); // R3

    AST_RISE_NEVER_LOST: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((up_lat & $past(rises)) == $past(rises))); // R4

    AST_LEVEL_TRACKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (((irq ^ (up_en_q & ~(chan_in ^ dn_en_q))) & mode_q) == '0)); // R7

    AST_LEVEL_ACK_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == AW'('h24)) |=>
        (((dn_en_q ^ $past(dn_en_q)) & $past(mode_q)) == ($past(wr_bits) & $past(mode_q)))); // R9
endmodule

bind pin_irq_unit pin_irq_unit_chk #(.CH(CH), .AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .wr_bits   (bus_wdata[CH-1:0]),
    .bus_rdata (bus_rdata),
    .chan_in   (chan_in),
    .irq       (irq),
    .mode_q    (mode_q),
    .up_en_q   (up_en_q),
    .dn_en_q   (dn_en_q),
    .up_lat    (up_lat)
);

// File: tb/pin_irq_unit_bench.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module pin_irq_unit_bench;
    localparam int CH = 8;
    localparam int AW = 6;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic [CH-1:0] chan_in = '0;
    logic [CH-1:0] irq;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    pin_irq_unit #(.CH(CH), .AW(AW), .DW(DW)) u_pin_irq_unit (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .chan_in(chan_in), .irq(irq)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_chk(input int a, input logic [DW-1:0] exp, input string req);
        @(negedge clk);
        bus_addr = AW'(a);
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic irq_chk(input logic [CH-1:0] exp, input string req);
        @(negedge clk);
        #1;
        check(req, DW'(irq), DW'(exp));
    endtask

    task automatic drive(input logic [CH-1:0] v);
        @(negedge clk);
        chan_in = v;
    endtask

    task automatic clean();
        wr('h00, 0); wr('h04, 0); wr('h10, 0);
        drive('0);
        @(negedge clk);
        wr('h1C, '1); wr('h20, '1);
    endtask

    task automatic t_reset();
        for (int a = 0; a <= 'h24; a += 4) rd_chk(a, 0, "R1 reset register");
        irq_chk('0, "R1 reset irq");
    endtask

    task automatic t_direct();
        clean();
        wr('h04, 'hA5); rd_chk('h04, 'hA5, "R2 up-enable");
        wr('h10, 'h3C); rd_chk('h10, 'h3C, "R2 down-enable");
        wr('h00, 'h0F); rd_chk('h00, 'h0F, "R2 mode");
        wr('h04, 'hFFFF_FFFF); rd_chk('h04, 'hFF, "R11 upper bits");
        rd_chk('h08, 0, "R11 alias read");
        rd_chk('h18, 0, "R11 alias read");
        rd_chk('h28, 0, "R11 unmapped read");
    endtask

    task automatic t_alias();
        clean();
        wr('h04, 'h0F);
        wr('h08, 'h30); rd_chk('h04, 'h3F, "R3 up set alias");
        wr('h0C, 'h05); rd_chk('h04, 'h3A, "R3 up clear alias");
        wr('h08, 'h00); rd_chk('h04, 'h3A, "R3 zero set no effect");
        wr('h0C, 'h00); rd_chk('h04, 'h3A, "R3 zero clear no effect");
        wr('h14, 'h81); rd_chk('h10, 'h81, "R3 down set alias");
        wr('h18, 'h80); rd_chk('h10, 'h01, "R3 down clear alias");
    endtask

    task automatic t_capture();
        clean();
        drive('h81);
        rd_chk('h1C, 'h81, "R4 rise latched");
        rd_chk('h20, 'h00, "R4 no fall yet");
        irq_chk('0, "R6 disabled edges quiet");
        drive('h01);
        rd_chk('h20, 'h80, "R4 fall latched");
        rd_chk('h1C, 'h81, "R4 rise kept");
    endtask

    task automatic t_w1c();
        wr('h1C, 'h01); rd_chk('h1C, 'h80, "R5 rise w1c");
        wr('h20, 'h80); rd_chk('h20, 'h00, "R5 fall w1c");
        // Edge on bit 2 in the same cycle as its clear.
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = AW'('h1C); bus_wdata = 'h04; chan_in = 'h05;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
        rd_chk('h1C, 'h84, "R5 edge beats clear");
    endtask

    task automatic t_edge();
        clean();
        wr('h04, 'h02); wr('h10, 'h06);
        drive('h02);
        irq_chk('h02, "R6 rising fires");
        wr('h24, 'h00); irq_chk('h02, "R8 zero ack no effect");
        wr('h24, 'h02); irq_chk('h00, "R8 ack clears");
        rd_chk('h1C, 'h00, "R8 up-latch cleared");
        drive('h06);
        irq_chk('h00, "R6 rise without enable quiet");
        drive('h02);
        irq_chk('h04, "R6 falling fires");
        drive('h00);
        irq_chk('h06, "R6 both edges enabled");
        rd_chk('h24, 'h06, "R10 request readback");
    endtask

    task automatic t_level();
        clean();
        wr('h00, 'h10); wr('h04, 'h10); wr('h10, 'h10);
        irq_chk('h00, "R7 high polarity, input low");
        drive('h10);
        irq_chk('h10, "R7 high polarity, input high");
        rd_chk('h24, 'h10, "R10 request readback level");
        wr('h18, 'h10);
        irq_chk('h00, "R7 low polarity, input high");
        drive('h00);
        irq_chk('h10, "R7 low polarity, input low");
        wr('h24, 'h10);
        rd_chk('h10, 'h10, "R9 ack flips polarity");
        irq_chk('h00, "R9 request after flip");
        rd_chk('h1C, 'h10, "R9 up-latch untouched");
        rd_chk('h20, 'h10, "R9 down-latch untouched");
    endtask

    initial begin
        #(5.0 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_direct();
        t_alias();
        t_capture();
        t_w1c();
        t_edge();
        t_level();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule